// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Compare-Match Waveform Output

This block is an up-counting timer that moves forward one step per qualified tick. It has two counting behaviours. In free-running mode the count runs up to its maximum, wraps to zero and raises a sticky overflow flag. In clear-on-compare mode the compare register sets the top of the count. Software-side writes can load the count, the compare value and a control word at any time. The control word holds the counting mode and the output action.

A compare unit watches for equality between the count and the compare register on each tick. On equality it raises a sticky match flag and applies the selected action to a waveform bit: hold, toggle, clear or set. A force strobe applies the same action at once without a real match. The waveform bit reaches the output pin only while the output enable is high, so the bit can be given a starting level before the pin is driven.

Top module: `tmr_cmp_top`

## Requirements
- R1: After reset, the count, the compare value, both flags and the waveform bit are zero, the mode is free-running (00) and the action is hold (00).
- R2: Each cycle with `tick` high and no count write, the count increases by one and wraps from 0xFF to 0x00. Without `tick` the count holds.
- R3: `ovf_flag` is set on the same edge where the count wraps from 0xFF to 0x00. It stays set until `ovf_clr` is high. If a set and a clear fall in the same cycle, the set wins.
- R4: With mode code 10 (clear-on-compare), a tick while the count equals the compare value loads zero into the count.
- R5: Mode codes 01 and 11 count exactly like free-running mode (00), so the count passes the compare value without being cleared.
- R6: `match_flag` is set on the edge of a tick where the count equals the compare value, in every mode. It stays set until `match_clr` is high. A set wins over a clear in the same cycle.
- R7: On a match, action code 00 leaves the waveform bit unchanged, 01 toggles it, 10 clears it and 11 sets it.
- R8: Writing a new action code does not change the waveform bit by itself. The new code acts from the next match or force onward.
- R9: `force_cmp` applies the current action to the waveform bit on the next edge. It does not set `match_flag` and does not clear the count in clear-on-compare mode.
- R10: `wave_pin` equals the waveform bit while `wave_oe` is high and is 0 while it is low. The bit can be changed while the pin is disabled.
- R11: `cnt_wr` loads `cnt_wdata` on the next edge whatever `tick` is. In that cycle no match and no overflow are detected.
- R12: `cmp_wr` loads the compare value on the next edge, and the following ticks compare against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse |
| cnt_wr | input | 1 | Load the count |
| cnt_wdata | input | 8 | Value for the count load |
| cmp_wr | input | 1 | Load the compare value |
| cmp_wdata | input | 8 | Value for the compare load |
| ctl_wr | input | 1 | Load mode and action codes |
| ctl_mode | input | 2 | Mode code: 10 clear-on-compare, others free-running |
| ctl_act | input | 2 | Action code: 00 hold, 01 toggle, 10 clear, 11 set |
| force_cmp | input | 1 | Apply the action without a match |
| ovf_clr | input | 1 | Clear the overflow flag |
| match_clr | input | 1 | Clear the match flag |
| wave_oe | input | 1 | Output enable for the waveform pin |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare-match flag |
| wave_pin | output | 1 | Gated waveform bit |

## Verification
The hardest cases to reach are collisions on a single edge. These are a count write that coincides with a tick, either while the count equals the compare value or while it sits at 0xFF, and a flag clear that lands on the same edge as a new set. The stimulus first parks the count on the critical value with a tick-free write. It then raises the colliding strobes together in the next cycle, so the outcome of exactly that edge can be read from the flags and the count. The waveform bit is given a level while the pin is disabled, and that level is only observed after the enable returns.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_RSV1 = 2'b01,
    MODE_CTC  = 2'b10,
    MODE_RSV3 = 2'b11
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;
endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clr_i |=> flag_o); // R3 R6
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o); // R3 R6
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         ctc_en,
  input  logic         at_cmp,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assign wrap = tick && !ld && (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (ld)              cnt <= ld_val;
    else if (tick) begin
      if (ctc_en && at_cmp)   cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick && !ld |=> $stable(cnt)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt == $past(ld_val)); // R11
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [W-1:0] cnt,
  input  logic         tick,
  input  logic         ld,
  output logic         at_cmp,
  output logic         match_evt
);
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '0;
    else if (cmp_wr) cmp_q <= cmp_wdata;
  end

  assign at_cmp    = (cnt == cmp_q);
  assign match_evt = tick && !ld && at_cmp;

  AST_LOAD_BLOCKS_MATCH: assert property (@(posedge clk) disable iff (rst)
    ld |-> !match_evt); // R11
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  cmp_act_e   act_wdata,
  input  logic       match_evt,
  input  logic       force_cmp,
  input  logic       oe,
  output logic       wave_pin
);
  cmp_act_e act_q;
  logic     wave_bit;
  logic     apply;

  assign apply = match_evt || force_cmp;

  always_ff @(posedge clk) begin
    if (rst)         act_q <= ACT_HOLD;
    else if (ctl_wr) act_q <= act_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) wave_bit <= 1'b0;
    else if (apply) begin
      case (act_q)
        ACT_TOGGLE: wave_bit <= ~wave_bit;
        ACT_CLEAR:  wave_bit <= 1'b0;
        ACT_SET:    wave_bit <= 1'b1;
        default:    wave_bit <= wave_bit;
      endcase
    end
  end

  assign wave_pin = wave_bit && oe;

  AST_HOLD_ACTION: assert property (@(posedge clk) disable iff (rst)
    act_q == ACT_HOLD |=> $stable(wave_bit)); // R7
  AST_NO_APPLY_STABLE: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(wave_bit)); // R8
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !wave_pin); // R10
endmodule

// File: rtl/tmr_cmp_top.sv
module tmr_cmp_top
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         ctl_wr,
  input  logic [1:0]   ctl_mode,
  input  logic [1:0]   ctl_act,
  input  logic         force_cmp,
  input  logic         ovf_clr,
  input  logic         match_clr,
  input  logic         wave_oe,
  output logic [W-1:0] cnt_q,
  output logic         ovf_flag,
  output logic         match_flag,
  output logic         wave_pin
);
  tmr_mode_e mode_q;
  logic      ctc_en;
  logic      at_cmp;
  logic      match_evt;
  logic      wrap;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_FREE;
    else if (ctl_wr) mode_q <= tmr_mode_e'(ctl_mode);
  end

  assign ctc_en = (mode_q == MODE_CTC);

  tmr_count #(.W(W)) count_i (
    .clk(clk), .rst(rst), .tick(tick), .ld(cnt_wr), .ld_val(cnt_wdata),
    .ctc_en(ctc_en), .at_cmp(at_cmp), .cnt(cnt_q), .wrap(wrap)
  );

  tmr_compare #(.W(W)) cmp_i (
    .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cnt(cnt_q), .tick(tick), .ld(cnt_wr), .at_cmp(at_cmp),
    .match_evt(match_evt)
  );

  tmr_flag ovf_i (
    .clk(clk), .rst(rst), .set_i(wrap), .clr_i(ovf_clr), .flag_o(ovf_flag)
  );

  tmr_flag match_i (
    .clk(clk), .rst(rst), .set_i(match_evt), .clr_i(match_clr),
    .flag_o(match_flag)
  );

  tmr_wave wave_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .act_wdata(cmp_act_e'(ctl_act)),
    .match_evt(match_evt), .force_cmp(force_cmp), .oe(wave_oe),
    .wave_pin(wave_pin)
  );

  AST_CTC_TOP: assert property (@(posedge clk) disable iff (rst)
    ctc_en && match_evt |=> cnt_q == '0); // R4
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    force_cmp && !match_evt && !match_flag |=> !match_flag); // R9
  AST_LOAD_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    cnt_wr && !match_flag |=> !match_flag); // R11
  AST_WRAP_OVF: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_flag && cnt_q == '0); // R3
endmodule

// File: tb/tmr_cmp_top_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 0, cnt_wr = 0, cmp_wr = 0, ctl_wr = 0;
  logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [1:0] ctl_mode = 0, ctl_act = 0;
  logic       force_cmp = 0, ovf_clr = 0, match_clr = 0, wave_oe = 1;
  logic [7:0] cnt_q;
  logic       ovf_flag, match_flag, wave_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_cmp_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ctl_wr(ctl_wr),
    .ctl_mode(ctl_mode), .ctl_act(ctl_act), .force_cmp(force_cmp),
    .ovf_clr(ovf_clr), .match_clr(match_clr), .wave_oe(wave_oe),
    .cnt_q(cnt_q), .ovf_flag(ovf_flag), .match_flag(match_flag),
    .wave_pin(wave_pin)
  );

  // {tick, cnt_wr, wdata[7:0], exp_cnt[7:0], exp_ovf, exp_match}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'hFD, 8'hFD, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'hFE, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'hFE, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 8'h01, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h00, 8'h02, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tick = 0; cnt_wr = 0; cmp_wr = 0; ctl_wr = 0;
    force_cmp = 0; ovf_clr = 0; match_clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      step();
    end
  endtask

  task automatic load(input logic [7:0] v);
    cnt_wr = 1; cnt_wdata = v; step();
  endtask

  task automatic ctl(input logic [1:0] m, input logic [1:0] a);
    ctl_wr = 1; ctl_mode = m; ctl_act = a; step();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 cnt", cnt_q, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 match", match_flag, 0);
    chk("R1 pin", wave_pin, 0);

    // R2 R3 R6 vector walk in free-running mode, compare value 0
    for (int k = 0; k < NV; k++) begin
      tick = VEC[k][19]; cnt_wr = VEC[k][18]; cnt_wdata = VEC[k][17:10];
      step();
      chk("R2 cnt", cnt_q, VEC[k][9:2]);
      chk("R3 ovf", ovf_flag, VEC[k][1]);
      chk("R6 match", match_flag, VEC[k][0]);
    end

    // R3 / R6 clear inputs
    ovf_clr = 1; step();
    chk("R3 ovf clear", ovf_flag, 0);
    match_clr = 1; step();
    chk("R6 match clear", match_flag, 0);

    // R3 set wins over clear
    load(8'hFF);
    tick = 1; ovf_clr = 1; step();
    chk("R3 set wins", ovf_flag, 1);
    chk("R2 wrap", cnt_q, 0);
    // R6 set wins over clear (count 0 equals compare 0)
    tick = 1; match_clr = 1; step();
    chk("R6 set wins", match_flag, 1);
    ovf_clr = 1; match_clr = 1; step();

    // R11 a write at 0xFF with a tick blocks the overflow
    load(8'hFF);
    tick = 1; cnt_wr = 1; cnt_wdata = 8'h10; step();
    chk("R11 load cnt", cnt_q, 8'h10);
    chk("R11 no ovf", ovf_flag, 0);

    // R5 reserved modes count past the compare value
    cmp_wr = 1; cmp_wdata = 8'h03; step();
    ctl(2'b01, 2'b00);
    load(8'h03);
    ticks(1);
    chk("R5 mode01 cnt", cnt_q, 4);
    chk("R6 match mode01", match_flag, 1);
    match_clr = 1; step();
    ctl(2'b11, 2'b00);
    load(8'h03);
    ticks(1);
    chk("R5 mode11 cnt", cnt_q, 4);
    match_clr = 1; step();

    // R4 R7 clear-on-compare with toggle action
    ctl(2'b10, 2'b01);
    load(8'h00);
    ticks(3);
    chk("R4 before top", cnt_q, 3);
    ticks(1);
    chk("R4 cleared", cnt_q, 0);
    chk("R7 toggle up", wave_pin, 1);
    ticks(4);
    chk("R7 toggle down", wave_pin, 0);

    // R12 new compare value takes effect
    cmp_wr = 1; cmp_wdata = 8'h01; step();
    ticks(2);
    chk("R12 new top", cnt_q, 0);
    chk("R7 toggle again", wave_pin, 1);

    // R8 action write alone does not move the bit
    ctl(2'b10, 2'b10);
    chk("R8 no change", wave_pin, 1);
    ticks(2);
    chk("R7 clear", wave_pin, 0);
    ctl(2'b10, 2'b11);
    ticks(2);
    chk("R7 set", wave_pin, 1);
    ctl(2'b10, 2'b00);
    ticks(2);
    chk("R7 hold", wave_pin, 1);

    // R9 force applies action, no flag, no clear
    match_clr = 1; step();
    ctl(2'b10, 2'b10);
    load(8'h01);
    force_cmp = 1; step();
    chk("R9 force pin", wave_pin, 0);
    chk("R9 force cnt", cnt_q, 1);
    chk("R9 force flag", match_flag, 0);

    // R10 output enable gate and preset while disabled
    ctl(2'b10, 2'b11);
    wave_oe = 0;
    force_cmp = 1; step();
    chk("R10 gated", wave_pin, 0);
    wave_oe = 1; step();
    chk("R10 enabled", wave_pin, 1);

    // R11 a write with a tick while count equals compare blocks the match
    load(8'h01);
    tick = 1; cnt_wr = 1; cnt_wdata = 8'h05; step();
    chk("R11 cnt", cnt_q, 5);
    chk("R11 no match", match_flag, 0);
    chk("R11 pin kept", wave_pin, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule